// File: doc/BRIEF.md
# Dual-Field Capture DMA Request Sequencer

This block decides when a video capture FIFO holds enough data to justify another DMA burst. The two interlaced fields each have their own burst size (threshold) and their own number of bursts per field. A sequencer walks through the bursts of field 1, then field 2, then wraps back to field 1. A small in-flight tracker records up to two issued bursts that are not yet finished. The oldest of these is the one being serviced. The DMA engine reads it out one doubleword at a time. An outgoing counter, loaded with the serviced burst's own field threshold, counts those reads down to completion.

A new request is raised only when the FIFO level is strictly greater than the sum of the thresholds still charged to in-flight bursts plus the threshold of the burst about to be issued. This lets the first field-2 request be raised early while a field-1 burst is still open, with no confusion about which threshold applies. A frame-start pulse rewinds the sequencer to the first burst of field 1 and leaves bursts already in flight alone.

The tracker is a three-state machine:
- S_IDLE: nothing in flight. The issue transition leads to S_SINGLE.
- S_SINGLE: one burst in flight.
  - issue leads to S_DOUBLE.
  - retire (the completing read) leads to S_IDLE.
  - retire+issue in the same cycle stays in S_SINGLE, and the new burst becomes the head.
- S_DOUBLE: two bursts in flight; no issue is possible here. Retire leads to S_SINGLE, and the younger burst becomes the head.

Top module: `vcap_dma_evgen`

## Requirements
- R1: After reset, `dma_evt` and `svc_done` are 0, `inflight` is 0 and `svc_left` is 0.
- R2: With nothing in flight, a request is issued when `fifo_level` is strictly greater than the threshold of the field whose burst is next. `dma_evt` is high for exactly the one cycle after the deciding clock edge. `evt_field` then gives that burst's field, encoded 0 = field 1 and 1 = field 2.
- R3: With one burst in flight, a request is issued only when `fifo_level` is strictly greater than the in-flight burst's field threshold plus the next burst's field threshold. Two cases follow: field 1 in flight with field 2 next needs more than thr_fld1+thr_fld2, and field 2 in flight with field 2 next needs more than twice thr_fld2.
- R4: No more than two bursts are ever in flight, and no request is issued while two are in flight, whatever the FIFO level.
- R5: Bursts are assigned `cnt_fld1` times to field 1, then `cnt_fld2` times to field 2, then back to field 1. A count of 0 behaves as 1.
- R6: When a burst becomes the head, `svc_left` is loaded with the threshold of that burst's field, not the field of the burst being issued. Each `dma_rd` while a burst is in flight lowers `svc_left` by one.
- R7: The read that brings `svc_left` to zero retires the head. `svc_done` pulses for one cycle, `inflight` drops by one, and any younger burst becomes the head with `svc_field` set to its field.
- R8: `dma_rd` with nothing in flight has no effect: `svc_left` stays 0, no `svc_done`, and a later burst still loads its full threshold.
- R9: `frame_start` rewinds the sequencer to the first field-1 burst and blocks any request in its own cycle. Bursts in flight and `svc_left` are left unchanged.
- R10: When a retire and an issue fall in the same cycle with one burst in flight, `inflight` stays at one. The new burst becomes the head with `svc_left` equal to its own field threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame-start pulse; rewinds the field sequencer |
| fifo_level | input | LVL_W | Capture FIFO occupancy in doublewords, unsigned |
| thr_fld1 | input | THR_W | Burst size for field 1, doublewords |
| thr_fld2 | input | THR_W | Burst size for field 2, doublewords |
| cnt_fld1 | input | CNT_W | Bursts per field 1 |
| cnt_fld2 | input | CNT_W | Bursts per field 2 |
| dma_rd | input | 1 | One doubleword read by the DMA this cycle |
| dma_evt | output | 1 | Single-cycle DMA request |
| evt_field | output | 1 | Field of the request on `dma_evt` (0 = field 1) |
| inflight | output | 2 | Bursts issued and not yet retired (0..2) |
| svc_field | output | 1 | Field of the burst being serviced |
| svc_left | output | THR_W | Outgoing counter: doublewords left in the serviced burst |
| svc_done | output | 1 | Single-cycle pulse after the serviced burst retires |

## Verification
The request decision is combinational on the registered state and the present inputs, and every output is registered. So `dma_evt`, `evt_field`, `svc_done`, `inflight`, `svc_field` and `svc_left` all reflect a stimulus exactly one clock edge after it is applied. The bench changes inputs on the falling edge and reads outputs at the next falling edge, one edge later. Read bursts of k cycles are therefore checked right after the k-th edge, and the FIFO level is returned to zero in the cycle after each issue, so the strict-greater boundaries (equal fails, one more fires) are probed one edge at a time.

// File: rtl/vcap_evg_pkg.sv
package vcap_evg_pkg;

    // Field tag carried by every burst: 0 selects field 1, 1 selects field 2.
    typedef enum logic {
        FLD_ONE = 1'b0,
        FLD_TWO = 1'b1
    } field_t;

    // Occupancy of the in-flight tracker.
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SINGLE = 2'd1,
        S_DOUBLE = 2'd2
    } slot_state_t;

endpackage

// File: rtl/vcap_evg_sequencer.sv
module vcap_evg_sequencer
    import vcap_evg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             fire,
    input  logic [CNT_W-1:0] cnt_fld1,
    input  logic [CNT_W-1:0] cnt_fld2,
    output field_t           next_field
);

    localparam int IDX_W = CNT_W + 1;

    field_t           field_q;
    field_t           field_n;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] idx_n;
    logic [IDX_W-1:0] idx_inc;
    logic [IDX_W-1:0] cnt_sel;
    logic             last_of_field;

    always_comb begin
        idx_inc       = {1'b0, idx_q} + IDX_W'(1);
        cnt_sel       = (field_q == FLD_TWO) ? {1'b0, cnt_fld2} : {1'b0, cnt_fld1};
        // A zero count still yields one burst for the field.
        last_of_field = (idx_inc >= cnt_sel);
    end

    always_comb begin
        field_n = field_q;
        idx_n   = idx_q;
        if (frame_start) begin
            field_n = FLD_ONE;
            idx_n   = '0;
        end else if (fire) begin
            if (last_of_field) begin
                field_n = (field_q == FLD_ONE) ? FLD_TWO : FLD_ONE;
                idx_n   = '0;
            end else begin
                idx_n = idx_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= FLD_ONE;
            idx_q   <= '0;
        end else begin
            field_q <= field_n;
            idx_q   <= idx_n;
        end
    end

    assign next_field = field_q;

endmodule

// File: rtl/vcap_evg_trigger.sv
module vcap_evg_trigger
    import vcap_evg_pkg::*;
#(
    parameter int LVL_W = 12,
    parameter int THR_W = 10
) (
    input  slot_state_t      slot_state,
    input  field_t           head_field,
    input  field_t           next_field,
    input  logic             frame_start,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [THR_W-1:0] thr_fld1,
    input  logic [THR_W-1:0] thr_fld2,
    output logic             fire
);

    localparam int SUM_W = THR_W + 1;
    localparam int CMP_W = (LVL_W > SUM_W) ? LVL_W : SUM_W;

    logic [THR_W-1:0] thr_next;
    logic [THR_W-1:0] thr_held;
    logic [SUM_W-1:0] need;

    always_comb begin
        thr_next = (next_field == FLD_TWO) ? thr_fld2 : thr_fld1;
        unique case (slot_state)
            S_SINGLE: thr_held = (head_field == FLD_TWO) ? thr_fld2 : thr_fld1;
            default:  thr_held = '0;
        endcase
        // The full threshold of an open burst stays charged until it retires.
        need = SUM_W'(thr_held) + SUM_W'(thr_next);
        fire = (slot_state != S_DOUBLE) && !frame_start &&
               (CMP_W'(fifo_level) > CMP_W'(need));
    end

endmodule

// File: rtl/vcap_evg_slots.sv
module vcap_evg_slots
    import vcap_evg_pkg::*;
#(
    parameter int THR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  field_t           fire_field,
    input  logic             dma_rd,
    input  logic [THR_W-1:0] thr_fld1,
    input  logic [THR_W-1:0] thr_fld2,
    output slot_state_t      slot_state,
    output field_t           head_field,
    output logic [THR_W-1:0] svc_left,
    output logic [1:0]       inflight,
    output logic             svc_done
);

    slot_state_t      st_q, st_n;
    field_t           head_q, head_n;
    field_t           tail_q, tail_n;
    logic [THR_W-1:0] left_q, left_n;
    logic             retire;
    logic             done_q;
    logic [THR_W-1:0] thr_fire;
    logic [THR_W-1:0] thr_tail;
    logic             last_word;

    always_comb begin
        thr_fire  = (fire_field == FLD_TWO) ? thr_fld2 : thr_fld1;
        thr_tail  = (tail_q == FLD_TWO) ? thr_fld2 : thr_fld1;
        last_word = (left_q <= THR_W'(1));
    end

    // Next-state and datapath decisions.
    always_comb begin
        st_n   = st_q;
        head_n = head_q;
        tail_n = tail_q;
        left_n = left_q;
        retire = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (fire) begin
                    st_n   = S_SINGLE;
                    head_n = fire_field;
                    left_n = thr_fire;
                end
            end
            S_SINGLE: begin
                retire = dma_rd && last_word;
                if (retire && fire) begin
                    head_n = fire_field;
                    left_n = thr_fire;
                end else if (retire) begin
                    st_n   = S_IDLE;
                    left_n = '0;
                end else begin
                    if (fire) begin
                        st_n   = S_DOUBLE;
                        tail_n = fire_field;
                    end
                    if (dma_rd) begin
                        left_n = left_q - THR_W'(1);
                    end
                end
            end
            S_DOUBLE: begin
                retire = dma_rd && last_word;
                if (retire) begin
                    st_n   = S_SINGLE;
                    head_n = tail_q;
                    left_n = thr_tail;
                end else if (dma_rd) begin
                    left_n = left_q - THR_W'(1);
                end
            end
            default: begin
                st_n   = S_IDLE;
                left_n = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            head_q <= FLD_ONE;
            tail_q <= FLD_ONE;
            left_q <= '0;
        end else begin
            st_q   <= st_n;
            head_q <= head_n;
            tail_q <= tail_n;
            left_q <= left_n;
        end
    end

    // Registered completion pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= retire;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        unique case (st_q)
            S_SINGLE: inflight = 2'd1;
            S_DOUBLE: inflight = 2'd2;
            default:  inflight = 2'd0;
        endcase
    end

    assign slot_state = st_q;
    assign head_field = head_q;
    assign svc_left   = left_q;
    assign svc_done   = done_q;

endmodule

// File: rtl/vcap_dma_evgen.sv
module vcap_dma_evgen
    import vcap_evg_pkg::*;
#(
    parameter int LVL_W = 12,
    parameter int THR_W = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [THR_W-1:0] thr_fld1,
    input  logic [THR_W-1:0] thr_fld2,
    input  logic [CNT_W-1:0] cnt_fld1,
    input  logic [CNT_W-1:0] cnt_fld2,
    input  logic             dma_rd,
    output logic             dma_evt,
    output logic             evt_field,
    output logic [1:0]       inflight,
    output logic             svc_field,
    output logic [THR_W-1:0] svc_left,
    output logic             svc_done
);

    field_t      next_field;
    field_t      head_field;
    slot_state_t slot_state;
    logic        fire;
    logic        evt_q;
    field_t      evt_field_q;

    vcap_evg_sequencer #(
        .CNT_W(CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .fire       (fire),
        .cnt_fld1   (cnt_fld1),
        .cnt_fld2   (cnt_fld2),
        .next_field (next_field)
    );

    vcap_evg_trigger #(
        .LVL_W(LVL_W),
        .THR_W(THR_W)
    ) u_trig (
        .slot_state (slot_state),
        .head_field (head_field),
        .next_field (next_field),
        .frame_start(frame_start),
        .fifo_level (fifo_level),
        .thr_fld1   (thr_fld1),
        .thr_fld2   (thr_fld2),
        .fire       (fire)
    );

    vcap_evg_slots #(
        .THR_W(THR_W)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .fire_field(next_field),
        .dma_rd    (dma_rd),
        .thr_fld1  (thr_fld1),
        .thr_fld2  (thr_fld2),
        .slot_state(slot_state),
        .head_field(head_field),
        .svc_left  (svc_left),
        .inflight  (inflight),
        .svc_done  (svc_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q       <= 1'b0;
            evt_field_q <= FLD_ONE;
        end else begin
            evt_q <= fire;
            if (fire) begin
                evt_field_q <= next_field;
            end
        end
    end

    assign dma_evt   = evt_q;
    assign evt_field = evt_field_q;
    assign svc_field = head_field;

endmodule

// File: rtl/vcap_dma_evgen_chk.sv
module vcap_dma_evgen_chk #(
    parameter int LVL_W = 12,
    parameter int THR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic [LVL_W-1:0] fifo_level,
    input logic [THR_W-1:0] thr_fld1,
    input logic [THR_W-1:0] thr_fld2,
    input logic             dma_rd,
    input logic             dma_evt,
    input logic             evt_field,
    input logic [1:0]       inflight,
    input logic [THR_W-1:0] svc_left,
    input logic             svc_done
);

    p_empty_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == 2'd0 && fifo_level == '0) |=> !dma_evt);

    p_cap_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 2'd2);

    p_full_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == 2'd2) |=> !dma_evt);

    p_load_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == 2'd0) |=> (dma_evt |-> svc_left == (evt_field ? thr_fld2 : thr_fld1)));

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight != 2'd0 && dma_rd && svc_left > THR_W'(1)) |=> svc_left == $past(svc_left) - THR_W'(1));

    p_done_from_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |-> $past(dma_rd));

    p_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == 2'd0 && dma_rd) |=> (!svc_done && svc_left == '0));

    p_frame_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !dma_evt);

    p_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && dma_evt) |-> inflight == $past(inflight));

endmodule

bind vcap_dma_evgen vcap_dma_evgen_chk #(
    .LVL_W(LVL_W),
    .THR_W(THR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .fifo_level (fifo_level),
    .thr_fld1   (thr_fld1),
    .thr_fld2   (thr_fld2),
    .dma_rd     (dma_rd),
    .dma_evt    (dma_evt),
    .evt_field  (evt_field),
    .inflight   (inflight),
    .svc_left   (svc_left),
    .svc_done   (svc_done)
);

// File: tb/vcap_dma_evgen_bench.sv
module vcap_dma_evgen_bench;

    localparam int LVL_W = 12;
    localparam int THR_W = 10;
    localparam int CNT_W = 8;
    localparam int T1 = 4;
    localparam int T2 = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             frame_start;
    logic [LVL_W-1:0] fifo_level;
    logic [THR_W-1:0] thr_fld1;
    logic [THR_W-1:0] thr_fld2;
    logic [CNT_W-1:0] cnt_fld1;
    logic [CNT_W-1:0] cnt_fld2;
    logic             dma_rd;
    logic             dma_evt;
    logic             evt_field;
    logic [1:0]       inflight;
    logic             svc_field;
    logic [THR_W-1:0] svc_left;
    logic             svc_done;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    vcap_dma_evgen #(
        .LVL_W(LVL_W),
        .THR_W(THR_W),
        .CNT_W(CNT_W)
    ) u_vcap_dma_evgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .fifo_level (fifo_level),
        .thr_fld1   (thr_fld1),
        .thr_fld2   (thr_fld2),
        .cnt_fld1   (cnt_fld1),
        .cnt_fld2   (cnt_fld2),
        .dma_rd     (dma_rd),
        .dma_evt    (dma_evt),
        .evt_field  (evt_field),
        .inflight   (inflight),
        .svc_field  (svc_field),
        .svc_left   (svc_left),
        .svc_done   (svc_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reads(input int n);
        dma_rd = 1'b1;
        tick(n);
        dma_rd = 1'b0;
    endtask

    task automatic issue(input int lvl);
        fifo_level = LVL_W'(lvl);
        tick(1);
        fifo_level = '0;
    endtask

    task automatic do_reset;
        rst_n       = 1'b0;
        frame_start = 1'b0;
        fifo_level  = '0;
        thr_fld1    = THR_W'(T1);
        thr_fld2    = THR_W'(T2);
        cnt_fld1    = CNT_W'(2);
        cnt_fld2    = CNT_W'(2);
        dma_rd      = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 dma_evt", int'(dma_evt), 0);
        chk("R1 svc_done", int'(svc_done), 0);
        chk("R1 inflight", int'(inflight), 0);
        chk("R1 svc_left", int'(svc_left), 0);
    endtask

    task automatic t_single;
        do_reset();
        issue(T1);
        chk("R2 level equal to threshold", int'(dma_evt), 0);
        issue(T1 + 1);
        chk("R2 event", int'(dma_evt), 1);
        chk("R2 evt_field", int'(evt_field), 0);
        chk("R6 load thr1", int'(svc_left), T1);
        chk("R2 inflight", int'(inflight), 1);
        tick(1);
        chk("R2 single-cycle pulse", int'(dma_evt), 0);
        reads(2);
        chk("R6 countdown", int'(svc_left), T1 - 2);
        chk("R7 not yet done", int'(svc_done), 0);
        reads(2);
        chk("R7 done pulse", int'(svc_done), 1);
        chk("R7 inflight drop", int'(inflight), 0);
        tick(1);
        chk("R7 done single-cycle", int'(svc_done), 0);
    endtask

    task automatic t_fields;
        do_reset();
        issue(T1 + 1);
        chk("R2 first f1", int'(dma_evt), 1);
        issue(2 * T1);
        chk("R3 f1+f1 equal sum", int'(dma_evt), 0);
        issue(2 * T1 + 1);
        chk("R3 f1+f1 above sum", int'(dma_evt), 1);
        chk("R5 second burst f1", int'(evt_field), 0);
        chk("R4 two in flight", int'(inflight), 2);
        fifo_level = LVL_W'(200);
        tick(3);
        chk("R4 blocked when full", int'(dma_evt), 0);
        chk("R4 still two", int'(inflight), 2);
        fifo_level = '0;
        reads(T1);
        chk("R7 retire to one", int'(inflight), 1);
        chk("R7 done", int'(svc_done), 1);
        chk("R7 younger head field", int'(svc_field), 0);
        chk("R6 reload thr1", int'(svc_left), T1);
        issue(T1 + T2);
        chk("R3 f1+f2 equal sum", int'(dma_evt), 0);
        issue(T1 + T2 + 1);
        chk("R3 early f2 event", int'(dma_evt), 1);
        chk("R5 switch to f2", int'(evt_field), 1);
        reads(T1);
        chk("R6 serviced field thr2", int'(svc_left), T2);
        chk("R7 head now f2", int'(svc_field), 1);
        issue(2 * T2);
        chk("R3 twice thr2 equal", int'(dma_evt), 0);
        issue(2 * T2 + 1);
        chk("R3 twice thr2 above", int'(dma_evt), 1);
        chk("R5 second f2", int'(evt_field), 1);
        reads(T2);
        chk("R6 reload thr2", int'(svc_left), T2);
        reads(T2);
        chk("R7 drained", int'(inflight), 0);
        issue(T1 + 1);
        chk("R5 wrap event", int'(dma_evt), 1);
        chk("R5 wrap to f1", int'(evt_field), 0);
    endtask

    task automatic t_idle_reads;
        do_reset();
        reads(3);
        chk("R8 no done", int'(svc_done), 0);
        chk("R8 left zero", int'(svc_left), 0);
        chk("R8 inflight zero", int'(inflight), 0);
        issue(T1 + 1);
        chk("R8 full load after idle reads", int'(svc_left), T1);
    endtask

    task automatic t_frame;
        do_reset();
        issue(T1 + 1);
        chk("R9 setup event", int'(dma_evt), 1);
        frame_start = 1'b1;
        fifo_level  = LVL_W'(200);
        tick(1);
        frame_start = 1'b0;
        fifo_level  = '0;
        chk("R9 blocked", int'(dma_evt), 0);
        chk("R9 inflight kept", int'(inflight), 1);
        chk("R9 left kept", int'(svc_left), T1);
        reads(T1);
        issue(T1 + 1);
        chk("R9 rewound f1", int'(evt_field), 0);
        reads(T1);
        issue(T1 + 1);
        chk("R9 second after rewind f1", int'(evt_field), 0);
        chk("R9 event present", int'(dma_evt), 1);
    endtask

    task automatic t_swap;
        do_reset();
        issue(T1 + 1);
        reads(T1 - 1);
        chk("R10 one word left", int'(svc_left), 1);
        dma_rd     = 1'b1;
        fifo_level = LVL_W'(2 * T1 + 1);
        tick(1);
        dma_rd     = 1'b0;
        fifo_level = '0;
        chk("R10 event", int'(dma_evt), 1);
        chk("R10 done", int'(svc_done), 1);
        chk("R10 inflight one", int'(inflight), 1);
        chk("R10 new head load", int'(svc_left), T1);
    endtask

    initial begin
        #(8 * 20000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_fields();
        t_idle_reads();
        t_frame();
        t_swap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule